// File: doc/BRIEF.md
# Event Counting Performance Monitor

This block counts hardware events for performance analysis. It holds sixteen 48-bit counters. Each counter chooses one line of a 256-wide vector of single-cycle event strobes, using an 8-bit selector code. A counter advances only when three conditions hold together: a global run bit is set, its own enable bit is set, and its chosen strobe is high.

When a counter wraps past its maximum value, it raises a sticky overflow flag. Software clears that flag by writing a one to a clear register. One level-sensitive interrupt output combines all flags that are not masked.

All access goes through a simple synchronous register bus. Counters are 64-bit registers whose top 16 bits read as zero. Control registers are 32 bits wide and are returned zero-extended on the 64-bit read bus. Read data is registered and returns one clock after the request.

Top module: `evmon_unit`

## Requirements
- R1: Each counter is 48 bits wide. A counter read returns the value in bits 47:0 with bits 63:48 zero. Bits 63:48 of a counter write are ignored.
- R2: Counter i is read and written at address 0x1F00 + 8*i, for i = 0..15.
- R3: The selector code of counter i is held in the 32-bit register at 0x1E80 + 4*(i/4), in bits 8*(i%4)+7 down to 8*(i%4). Writing and then reading back returns all four codes of that register.
- R4: On a clock edge, counter i increments by one when all three hold: bit 0 of 0x1E00 is 1, bit i of 0x1E04 is 1, and the strobe indexed by its code is 1.
- R5: Code 0xFF never counts, even while strobe 255 is high.
- R6: Clearing bit 0 of 0x1E00 freezes every counter. Clearing bit i of 0x1E04 freezes only counter i.
- R7: An increment from 2^48-1 wraps the counter to 0 and sets bit i of the status register at 0x0808.
- R8: Writing 0x080C clears every status bit written as 1 and leaves bits written as 0 unchanged. An overflow in the same cycle as the clear of that bit leaves the bit set.
- R9: The irq output equals the OR, over all counters, of (status bit AND NOT mask bit), with the mask at 0x0804. A mask bit of 1 blocks that counter.
- R10: After reset, all counters, status bits, enables and the run bit are 0, all mask bits are 1, and every selector code is 0xFF.
- R11: A bus write to a counter in the same cycle as a qualifying increment loads the written value, and no overflow is flagged.
- R12: bus_rvalid is high exactly in the cycle after bus_rd. bus_rdata then shows the state from before that clock edge. Unmapped addresses and the clear register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_strobe | input | 256 | Single-cycle event strobes, indexed by selector code |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 64 | Write data; control registers use bits 31:0 |
| bus_rdata | output | 64 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Level interrupt from unmasked overflow flags |

## Verification
Every result appears one clock edge after its cause:
- A write, or a strobe sampled at an edge, changes the counters, enables, codes and status registers right after that edge.
- The irq output is combinational from the registered status and mask, so it moves in the same cycle as those registers.
- Read data and bus_rvalid appear in the cycle following bus_rd.

The bench drives inputs and compares outputs on the falling clock edge. It updates its behavioural model on the rising edge from the same inputs. Each expected read is queued at the edge that samples the request and checked at the next falling edge. irq is compared against the model on every cycle.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BUS_W  = 64;
  localparam int unsigned CTRL_W = 32;

  // register offsets; software decodes these, so they are fixed
  localparam logic [ADDR_W-1:0] A_MASK = 16'h0804;
  localparam logic [ADDR_W-1:0] A_STAT = 16'h0808;
  localparam logic [ADDR_W-1:0] A_CLR  = 16'h080C;
  localparam logic [ADDR_W-1:0] A_RUN  = 16'h1E00;
  localparam logic [ADDR_W-1:0] A_EN   = 16'h1E04;
  localparam logic [ADDR_W-1:0] A_SEL  = 16'h1E80;
  localparam logic [ADDR_W-1:0] A_CNT  = 16'h1F00;

  // address of the selector register holding the code of counter idx
  function automatic logic [ADDR_W-1:0] sel_addr(int idx, int per_reg);
    return A_SEL + ADDR_W'(4 * (idx / per_reg));
  endfunction

  // address of counter idx
  function automatic logic [ADDR_W-1:0] cnt_addr(int idx);
    return A_CNT + ADDR_W'(8 * idx);
  endfunction
endpackage

// File: rtl/evmon_ctrl.sv
module evmon_ctrl #(
  parameter int unsigned N_CNT  = 16,
  parameter int unsigned CODE_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr,
  input  logic [evmon_pkg::ADDR_W-1:0]          addr,
  input  logic [evmon_pkg::CTRL_W-1:0]          wdata,
  output logic                                  run,
  output logic [N_CNT-1:0]                      en,
  output logic [N_CNT-1:0]                      mask,
  output logic [N_CNT-1:0][CODE_W-1:0]          codes
);
  import evmon_pkg::*;
  localparam int unsigned PER_REG = CTRL_W / CODE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      en   <= '0;
      mask <= '1;
    end else if (wr) begin
      if (addr == A_RUN)  run  <= wdata[0];
      if (addr == A_EN)   en   <= wdata[N_CNT-1:0];
      if (addr == A_MASK) mask <= wdata[N_CNT-1:0];
    end
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_code
    localparam logic [ADDR_W-1:0] MY_ADDR = sel_addr(i, PER_REG);
    localparam int unsigned       LANE    = i % PER_REG;
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst)                         code_q <= '1;
      else if (wr && addr == MY_ADDR)  code_q <= wdata[LANE*CODE_W +: CODE_W];
    end
    assign codes[i] = code_q;

    p_code_load_r3: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == MY_ADDR) |=> (code_q == $past(wdata[LANE*CODE_W +: CODE_W])));
  end

  p_run_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == A_RUN) |=> $stable(run));
endmodule

// File: rtl/evmon_slot.sv
module evmon_slot #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned NUM_EV = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_EV-1:0] strobes,
  input  logic              wr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf
);
  localparam logic [CODE_W-1:0] CODE_NONE = '1;

  // arithmetic kept in one place: next value of a counter
  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur,
      logic load, logic [CNT_W-1:0] val, logic step);
    if (load)      return val;
    else if (step) return cur + 1'b1;
    return cur;
  endfunction

  logic ev_hit, inc;
  assign ev_hit = strobes[code];
  assign inc    = run & en & (code != CODE_NONE) & ev_hit;
  assign ovf    = inc & ~wr & (&cnt);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= next_count(cnt, wr, wdata, inc);
  end

  p_code_none_r5: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_NONE && !wr) |=> $stable(cnt));
  p_gated_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!(run && en) && !wr) |=> $stable(cnt));
  p_wr_wins_r11: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt == $past(wdata)));
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == '0));
endmodule

// File: rtl/evmon_status.sv
module evmon_status #(
  parameter int unsigned N_CNT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CNT-1:0] ovf_set,
  input  logic             clr_wr,
  input  logic [N_CNT-1:0] clr_bits,
  input  logic [N_CNT-1:0] mask,
  output logic [N_CNT-1:0] status,
  output logic             irq
);
  logic [N_CNT-1:0] clr_eff;
  assign clr_eff = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_eff) | ovf_set;
  end

  assign irq = |(status & ~mask);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_set != '0) |=> ((status & $past(ovf_set)) == $past(ovf_set)));
  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_set != '0) |=> (status != '0));
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && ovf_set == '0) |=> ((status & $past(clr_bits)) == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_wr && ovf_set == '0) |=> $stable(status));
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (&mask) |-> !irq);
endmodule

// File: rtl/evmon_unit.sv
module evmon_unit #(
  parameter int unsigned N_CNT  = 16,
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned NUM_EV = 1 << CODE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_EV-1:0]             ev_strobe,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [evmon_pkg::ADDR_W-1:0]  bus_addr,
  input  logic [evmon_pkg::BUS_W-1:0]   bus_wdata,
  output logic [evmon_pkg::BUS_W-1:0]   bus_rdata,
  output logic                          bus_rvalid,
  output logic                          irq
);
  import evmon_pkg::*;
  localparam int unsigned PER_REG = CTRL_W / CODE_W;
  localparam int unsigned N_SEL   = (N_CNT + PER_REG - 1) / PER_REG;

  logic                         run;
  logic [N_CNT-1:0]             en, mask, status, ovf_set;
  logic [N_CNT-1:0][CODE_W-1:0] codes;
  logic [N_CNT-1:0][CNT_W-1:0]  cnt_all;
  logic                         clr_wr;

  evmon_ctrl #(.N_CNT(N_CNT), .CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[CTRL_W-1:0]), .run(run), .en(en), .mask(mask),
    .codes(codes));

  for (genvar i = 0; i < N_CNT; i++) begin : g_slot
    logic slot_wr;
    assign slot_wr = bus_wr && (bus_addr == cnt_addr(i));
    evmon_slot #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_slot (
      .clk(clk), .rst(rst), .run(run), .en(en[i]), .code(codes[i]),
      .strobes(ev_strobe), .wr(slot_wr), .wdata(bus_wdata[CNT_W-1:0]),
      .cnt(cnt_all[i]), .ovf(ovf_set[i]));
  end

  assign clr_wr = bus_wr && (bus_addr == A_CLR);

  evmon_status #(.N_CNT(N_CNT)) u_status (
    .clk(clk), .rst(rst), .ovf_set(ovf_set), .clr_wr(clr_wr),
    .clr_bits(bus_wdata[N_CNT-1:0]), .mask(mask), .status(status), .irq(irq));

  // read selection
  logic [BUS_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (bus_addr == A_RUN)  rd_next[0] = run;
    if (bus_addr == A_EN)   rd_next[N_CNT-1:0] = en;
    if (bus_addr == A_MASK) rd_next[N_CNT-1:0] = mask;
    if (bus_addr == A_STAT) rd_next[N_CNT-1:0] = status;
    for (int k = 0; k < N_SEL; k++) begin
      if (bus_addr == A_SEL + ADDR_W'(4 * k)) begin
        for (int j = 0; j < PER_REG; j++) begin
          if (k * PER_REG + j < N_CNT)
            rd_next[j*CODE_W +: CODE_W] = codes[k*PER_REG + j];
        end
      end
    end
    for (int i = 0; i < N_CNT; i++) begin
      if (bus_addr == cnt_addr(i)) rd_next[CNT_W-1:0] = cnt_all[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_next : '0;
    end
  end

  p_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_no_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= A_CNT) |=> (bus_rdata[BUS_W-1:CNT_W] == '0));
endmodule

// File: tb/tb_evmon_unit.sv
`timescale 1ns/1ps
module tb_evmon_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic [255:0] ev_strobe;
  logic         bus_wr, bus_rd;
  logic [15:0]  bus_addr;
  logic [63:0]  bus_wdata;
  logic [63:0]  bus_rdata;
  logic         bus_rvalid;
  logic         irq;
  string        cur_tag;

  always #2 clk = ~clk;   // 250 MHz

  evmon_unit dut (
    .clk(clk), .rst(rst), .ev_strobe(ev_strobe), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq));

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  localparam longint unsigned M48 = (64'd1 << 48) - 1;
  longint unsigned m_cnt [16];
  bit [7:0]        m_code [16];
  bit              m_run;
  bit [15:0]       m_en, m_mask, m_stat;
  logic [63:0]     exp_q [$];
  string           tag_q [$];

  function automatic logic [63:0] model_read(logic [15:0] a);
    int k;
    if (a == 16'h1E00) return {63'd0, m_run};
    if (a == 16'h1E04) return {48'd0, m_en};
    if (a == 16'h0804) return {48'd0, m_mask};
    if (a == 16'h0808) return {48'd0, m_stat};
    if (a >= 16'h1E80 && a < 16'h1E90 && a[1:0] == 2'b00) begin
      k = int'(a - 16'h1E80) / 4;
      return {32'd0, m_code[4*k+3], m_code[4*k+2], m_code[4*k+1], m_code[4*k]};
    end
    if (a >= 16'h1F00 && a < 16'h1F80 && a[2:0] == 3'b000)
      return m_cnt[int'(a - 16'h1F00) / 8];
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_code[i] = 8'hFF; end
      m_run = 0; m_en = 0; m_mask = 16'hFFFF; m_stat = 0;
      exp_q.delete(); tag_q.delete();
    end else begin
      bit [15:0] wrap;
      bit [15:0] clr;
      bit        cnt_wr;
      int        widx;
      wrap = 0; clr = 0;
      if (bus_rd) begin exp_q.push_back(model_read(bus_addr)); tag_q.push_back(cur_tag); end
      cnt_wr = bus_wr && bus_addr >= 16'h1F00 && bus_addr < 16'h1F80 && bus_addr[2:0] == 0;
      widx = cnt_wr ? int'(bus_addr - 16'h1F00) / 8 : -1;
      for (int i = 0; i < 16; i++) begin
        bit step;
        step = m_run && m_en[i] && m_code[i] != 8'hFF && ev_strobe[m_code[i]];
        if (i == widx) m_cnt[i] = bus_wdata & M48;
        else if (step) begin
          if (m_cnt[i] == M48) begin m_cnt[i] = 0; wrap[i] = 1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (bus_wr) begin
        if (bus_addr == 16'h1E00) m_run = bus_wdata[0];
        if (bus_addr == 16'h1E04) m_en = bus_wdata[15:0];
        if (bus_addr == 16'h0804) m_mask = bus_wdata[15:0];
        if (bus_addr == 16'h080C) clr = bus_wdata[15:0];
        if (bus_addr >= 16'h1E80 && bus_addr < 16'h1E90 && bus_addr[1:0] == 0)
          for (int j = 0; j < 4; j++)
            m_code[4*(int'(bus_addr - 16'h1E80) / 4) + j] = bus_wdata[8*j +: 8];
      end
      m_stat = (m_stat & ~clr) | wrap;
    end
  end

  // ---------------- comparison on the falling edge ----------------
  always @(negedge clk) begin
    if (!rst && !done) begin
      compared++;
      if (irq !== |(m_stat & ~m_mask)) begin
        mismatched++;
        $display("FAIL R9 irq actual=%b expected=%b", irq, |(m_stat & ~m_mask));
      end
      compared++;
      if (bus_rvalid !== (exp_q.size() > 0)) begin
        mismatched++;
        $display("FAIL R12 rvalid actual=%b expected=%b", bus_rvalid, exp_q.size() > 0);
      end
      if (exp_q.size() > 0) begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (bus_rdata !== e) begin
          mismatched++;
          $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(bit w, bit r, logic [15:0] a, logic [63:0] d,
                      logic [255:0] ev, string t);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; ev_strobe = ev; cur_tag = t;
    @(negedge clk);
  endtask
  task automatic wr(logic [15:0] a, logic [63:0] d);
    step(1, 0, a, d, '0, "");
  endtask
  task automatic rd(logic [15:0] a, string t);
    step(0, 1, a, '0, '0, t);
  endtask
  task automatic evs(logic [255:0] ev, int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, ev, "");
  endtask
  function automatic logic [255:0] bit_of(int b);
    return 256'(1) << b;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; ev_strobe = 0; cur_tag = "";
    repeat (3) @(negedge clk);
    rst = 0;

    // R10: reset state
    rd(16'h1E00, "R10"); rd(16'h1E04, "R10"); rd(16'h0804, "R10"); rd(16'h0808, "R10");
    for (int k = 0; k < 4; k++) rd(16'h1E80 + 16'(4*k), "R10_R3");
    rd(16'h1F00, "R10"); rd(16'h1F78, "R10_R2");

    // R3: selector packing, counter 0 -> 0x05, counter 1 -> 0x10, others none
    wr(16'h1E80, 64'hFFFF_1005);
    wr(16'h1E84, 64'h1234_FFFF);          // counter 6 -> 0x34, counter 7 -> 0x12
    rd(16'h1E80, "R3"); rd(16'h1E84, "R3");
    wr(16'h1E84, 64'hFFFF_FFFF);

    // R4 / R5: counting with run and enables, counter 5 has code none
    wr(16'h1E04, 64'h0023);
    wr(16'h1E00, 64'h1);
    evs(bit_of(5), 3);
    evs(bit_of(16) | bit_of(255), 2);
    evs(bit_of(255), 2);
    rd(16'h1F00, "R4"); rd(16'h1F08, "R4"); rd(16'h1F28, "R5");

    // R6: global stop, then per-counter stop
    wr(16'h1E00, 64'h0);
    evs(bit_of(5) | bit_of(16), 3);
    rd(16'h1F00, "R6"); rd(16'h1F08, "R6");
    wr(16'h1E00, 64'h1);
    wr(16'h1E04, 64'h0021);
    evs(bit_of(5) | bit_of(16), 2);
    rd(16'h1F00, "R6"); rd(16'h1F08, "R6");

    // R1 / R2: counter 2 load with upper bits set
    wr(16'h1F10, 64'hABCD_FFFF_FFFF_FFFE);
    rd(16'h1F10, "R1_R2");

    // R7: wrap sets status
    wr(16'h1E80, 64'hFF07_1005);
    wr(16'h1E04, 64'h0025);
    evs(bit_of(7), 1);
    rd(16'h1F10, "R7");
    evs(bit_of(7), 1);
    rd(16'h1F10, "R7"); rd(16'h0808, "R7");
    evs(bit_of(7), 1);

    // R9: masking
    rd(16'h0808, "R9");
    wr(16'h0804, 64'hFFFB);
    evs('0, 2);
    wr(16'h0804, 64'hFFFF);
    evs('0, 1);
    wr(16'h0804, 64'hFFFB);

    // R8: zero bits do nothing, one bit clears
    wr(16'h080C, 64'h0000_FFFB);
    rd(16'h0808, "R8");
    wr(16'h080C, 64'h4);
    rd(16'h0808, "R8");

    // R8: overflow coincides with clear of the same bit
    wr(16'h1F10, 64'h0000_FFFF_FFFF_FFFF);
    step(1, 0, 16'h080C, 64'h4, bit_of(7), "");
    rd(16'h0808, "R8"); rd(16'h1F10, "R8");

    // R11: write beats increment, no overflow when writing over a max counter
    wr(16'h080C, 64'hFFFF);
    wr(16'h1F10, 64'h0000_FFFF_FFFF_FFFF);
    step(1, 0, 16'h1F10, 64'h0000_0000_0000_0042, bit_of(7), "");
    rd(16'h1F10, "R11"); rd(16'h0808, "R11");

    // R12: unmapped and clear register read as zero; read shows pre-edge state
    rd(16'h0100, "R12"); rd(16'h080C, "R12"); rd(16'h1F04, "R12");
    step(0, 1, 16'h1F10, '0, bit_of(7), "R12");
    rd(16'h1F10, "R12");

    // mixed traffic: all counters, several near wrap
    wr(16'h1E80, 64'h0302_0100);
    wr(16'h1E84, 64'h07FF_0504);
    wr(16'h1E88, 64'h0B0A_0908);
    wr(16'h1E8C, 64'h0F0E_0D0C);
    for (int i = 8; i < 16; i++) wr(16'h1F00 + 16'(8*i), 64'h0000_FFFF_FFFF_FFF0 + 64'(i));
    wr(16'h1E04, 64'hFFFF);
    wr(16'h0804, 64'h00FF);
    for (int c = 0; c < 300; c++) begin
      logic [255:0] ev;
      ev = {8{$urandom()}};
      if (c % 37 == 0) step(0, 1, 16'h0808, '0, ev, "R7");
      else if (c % 53 == 0) step(1, 0, 16'h080C, 64'(16'h0F0F), ev, "");
      else step(0, 0, '0, '0, ev, "");
    end
    for (int i = 0; i < 16; i++) rd(16'h1F00 + 16'(8*i), "R4");
    rd(16'h0808, "R7");
    evs('0, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule